// File: doc/BRIEF.md
# Character Blink Timing Generator

This block decides, for each character drawn on an on-screen display, whether its glyph dots are visible right now. A phase counter advances once per vertical sync pulse and sets the blink period. The period is either a long cycle (2^CNT_W pulses, 64 by default, about one second) or a short cycle of half that length. A two-bit duty code selects the part of each cycle during which blinking characters are hidden.

The character fetch logic presents the attributes of the character being drawn: its blink flag, its reverse flag and its background-enable flag. The block returns a glyph-visible flag, a reverse-rendering flag and a background flag. Only glyph dots are ever suppressed. The reverse and background flags pass through untouched.

Top module: `osd_blink_gen`

## Requirements
- R1: After a synchronous reset the phase count is zero and the long period is active, so the next cycle begins at the first vertical sync pulse counted.
- R2: The phase count changes only on clocks where `vsync_pulse` is 1, and by exactly one step. Clocks without a pulse leave `glyph_show` unchanged while the inputs are held.
- R3: With the active period select at 0, one cycle is 2^CNT_W pulses (64 by default). With it at 1, one cycle is 2^(CNT_W-1) pulses (32).
- R4: Let k be the phase count, that is the pulses since the cycle start, and P the active period. A blinking character is hidden exactly when k < P*d/4, where d is `duty_code`. Code 0 never hides, 1 hides for 25% of the cycle, 2 for 50% and 3 for 75%.
- R5: A new value on `period_sel` is adopted only at the pulse that wraps the count to zero. The cycle in progress always finishes at its old length.
- R6: When `attr_blink` is 0, `glyph_show` is 1 whatever the phase and duty.
- R7: `reverse_show` equals `attr_reverse` in every phase, hidden or not.
- R8: `bg_show` equals `bg_enable` in every phase, so a hidden character keeps its background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_pulse | input | 1 | One-clock pulse per vertical sync |
| period_sel | input | 1 | 0: long cycle, 1: half-length cycle |
| duty_code | input | 2 | Hidden fraction: 0 off, 1 25%, 2 50%, 3 75% |
| attr_blink | input | 1 | Blink attribute of the current character |
| attr_reverse | input | 1 | Reverse attribute of the current character |
| bg_enable | input | 1 | Background colouring enabled for the character |
| glyph_show | output | 1 | Character dots visible |
| reverse_show | output | 1 | Render with character and background swapped |
| bg_show | output | 1 | Draw the character background |

## Verification
The assertions check several properties on every cycle:
- the count holds between pulses and never passes the active period;
- the period select moves only on a wrapping pulse;
- the reset state;
- duty code 0 never hides;
- a character without the blink flag always shows.

The exact placement and length of each hidden window, and the delayed adoption of a mid-cycle period change, are shown only by the bench. The bench sweeps every duty code through complete cycles of both lengths against an arithmetic model of the phase.

// File: rtl/osd_blink_pkg.sv
package osd_blink_pkg;

    localparam int unsigned BLINK_CNT_W = 6;

    typedef enum logic [1:0] {
        DUTY_OFF = 2'd0,
        DUTY_25  = 2'd1,
        DUTY_50  = 2'd2,
        DUTY_75  = 2'd3
    } blink_duty_e;

    // Number of pulses, counted from the cycle start, during which a
    // blinking glyph is hidden.
    function automatic logic [31:0] hidden_span(logic [31:0] period, blink_duty_e duty);
        logic [31:0] prod;
        prod = period * {30'd0, duty};
        return prod >> 2;
    endfunction

endpackage

// File: rtl/osd_blink_phase.sv
module osd_blink_phase
    import osd_blink_pkg::*;
#(
    parameter int unsigned CNT_W = BLINK_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync_pulse,
    input  logic             period_sel,
    output logic [CNT_W-1:0] phase_cnt,
    output logic             short_act
);
    localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_LAST = {1'b0, {(CNT_W-1){1'b1}}};

    logic [CNT_W-1:0] last_step;
    logic             wrap_now;

    assign last_step = short_act ? SHORT_LAST : LONG_LAST;
    assign wrap_now  = vsync_pulse && (phase_cnt == last_step);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_cnt <= '0;
            short_act <= 1'b0;
        end else if (wrap_now) begin
            phase_cnt <= '0;
            short_act <= period_sel;
        end else if (vsync_pulse) begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R1: clean state right after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_cnt == '0 && !short_act));

    // R2: no pulse, no movement
    a_r2_hold_without_pulse: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(vsync_pulse) |-> $stable(phase_cnt));

    // R3: count stays inside the active period
    a_r3_within_period: assert property (@(posedge clk) disable iff (rst)
        short_act |-> (phase_cnt <= SHORT_LAST));

    // R5: period select switches only on a wrapping pulse
    a_r5_period_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$stable(short_act) |-> (phase_cnt == '0 && $past(vsync_pulse)));

endmodule

// File: rtl/osd_blink_window.sv
module osd_blink_window
    import osd_blink_pkg::*;
#(
    parameter int unsigned CNT_W = BLINK_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] phase_cnt,
    input  logic             short_act,
    input  blink_duty_e      duty,
    output logic             hide_now
);
    localparam logic [31:0] LONG_LEN  = 32'(1) << CNT_W;
    localparam logic [31:0] SHORT_LEN = 32'(1) << (CNT_W - 1);

    logic [31:0] period_len;
    logic [31:0] span;

    assign period_len = short_act ? SHORT_LEN : LONG_LEN;
    assign span       = hidden_span(period_len, duty);
    assign hide_now   = 32'(phase_cnt) < span;

    // R4: duty code off never opens a hidden window
    a_r4_off_never_hides: assert property (@(posedge clk) disable iff (rst)
        (duty == DUTY_OFF) |-> !hide_now);

endmodule

// File: rtl/osd_blink_gate.sv
module osd_blink_gate (
    input  logic hide_now,
    input  logic attr_blink,
    input  logic attr_reverse,
    input  logic bg_enable,
    output logic glyph_show,
    output logic reverse_show,
    output logic bg_show
);
    assign glyph_show   = !(attr_blink && hide_now);
    assign reverse_show = attr_reverse;
    assign bg_show      = bg_enable;
endmodule

// File: rtl/osd_blink_gen.sv
module osd_blink_gen
    import osd_blink_pkg::*;
#(
    parameter int unsigned CNT_W = BLINK_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync_pulse,
    input  logic       period_sel,
    input  logic [1:0] duty_code,
    input  logic       attr_blink,
    input  logic       attr_reverse,
    input  logic       bg_enable,
    output logic       glyph_show,
    output logic       reverse_show,
    output logic       bg_show
);
    logic [CNT_W-1:0] phase_cnt;
    logic             short_act;
    logic             hide_now;
    blink_duty_e      duty;

    assign duty = blink_duty_e'(duty_code);

    osd_blink_phase #(.CNT_W(CNT_W)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .vsync_pulse (vsync_pulse),
        .period_sel  (period_sel),
        .phase_cnt   (phase_cnt),
        .short_act   (short_act)
    );

    osd_blink_window #(.CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .phase_cnt (phase_cnt),
        .short_act (short_act),
        .duty      (duty),
        .hide_now  (hide_now)
    );

    osd_blink_gate u_gate (
        .hide_now     (hide_now),
        .attr_blink   (attr_blink),
        .attr_reverse (attr_reverse),
        .bg_enable    (bg_enable),
        .glyph_show   (glyph_show),
        .reverse_show (reverse_show),
        .bg_show      (bg_show)
    );

    // R6: characters without the blink flag are never suppressed
    a_r6_plain_always_shown: assert property (@(posedge clk) disable iff (rst)
        !attr_blink |-> glyph_show);

endmodule

// File: tb/osd_blink_gen_bench.sv
module osd_blink_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsync_pulse = 1'b0;
    logic       period_sel = 1'b0;
    logic [1:0] duty_code = 2'd0;
    logic       attr_blink = 1'b0;
    logic       attr_reverse = 1'b0;
    logic       bg_enable = 1'b0;
    logic       glyph_show, reverse_show, bg_show;

    int n_run  = 0;
    int n_fail = 0;
    int k_ref  = 0;
    int p_ref  = 64;

    always #10 clk = ~clk;

    osd_blink_gen u_osd_blink_gen (
        .clk          (clk),
        .rst          (rst),
        .vsync_pulse  (vsync_pulse),
        .period_sel   (period_sel),
        .duty_code    (duty_code),
        .attr_blink   (attr_blink),
        .attr_reverse (attr_reverse),
        .bg_enable    (bg_enable),
        .glyph_show   (glyph_show),
        .reverse_show (reverse_show),
        .bg_show      (bg_show)
    );

    task automatic check1(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s k=%0d P=%0d duty=%0d act=%b exp=%b",
                     req, k_ref, p_ref, duty_code, act, exp);
        end
    endtask

    function automatic logic exp_glyph();
        return !(attr_blink && (k_ref < (p_ref * int'(duty_code)) / 4));
    endfunction

    task automatic check_all(string req);
        check1(req, glyph_show, exp_glyph());
        check1("R7", reverse_show, attr_reverse);
        check1("R8", bg_show, bg_enable);
    endtask

    // one vsync pulse, model update, then check at the following negedge
    task automatic pulse(string req);
        @(negedge clk) vsync_pulse = 1'b1;
        @(negedge clk) vsync_pulse = 1'b0;
        if (k_ref == p_ref - 1) begin
            k_ref = 0;
            p_ref = period_sel ? 32 : 64;
        end else begin
            k_ref++;
        end
        check_all(req);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: fresh phase at zero with blinking off
        check1("R1", glyph_show, 1'b1);
        attr_blink = 1'b1;
        duty_code  = 2'd1;
        #1;
        check1("R1", glyph_show, 1'b0);   // k=0 lies in the first quarter

        // R2: clocks without pulses change nothing
        repeat (10) @(negedge clk);
        check1("R2", glyph_show, 1'b0);

        // R3/R4: long-period sweep of every duty code, whole cycles
        for (int d = 0; d < 4; d++) begin
            duty_code = 2'(d);
            for (int i = 0; i < 64; i++) begin
                attr_reverse = i[0];
                bg_enable    = i[1];
                pulse("R4");
            end
        end

        // R5: change select mid-cycle; old length must finish
        duty_code = 2'd2;
        for (int i = 0; i < 10; i++) pulse("R5");
        period_sel = 1'b1;
        for (int i = 0; i < 60; i++) pulse("R5");

        // R3/R4: short-period sweep
        for (int d = 0; d < 4; d++) begin
            duty_code = 2'(d);
            for (int i = 0; i < 32; i++) begin
                attr_reverse = i[1];
                bg_enable    = i[0];
                pulse("R3");
            end
        end

        // R6: blink flag clear shows glyph through a whole hidden window
        duty_code  = 2'd3;
        attr_blink = 1'b0;
        for (int i = 0; i < 32; i++) pulse("R6");

        // R7/R8: attributes pass while hidden
        attr_blink = 1'b1;
        for (int i = 0; i < 4; i++) begin
            attr_reverse = i[0];
            bg_enable    = i[1];
            #1;
            check_all("R8");
        end

        // switch back to long; R5 again
        period_sel = 1'b0;
        for (int i = 0; i < 100; i++) pulse("R5");

        // R1: reset mid-cycle restarts at zero with long period
        period_sel = 1'b1;
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        k_ref = 0;
        p_ref = 64;
        period_sel = 1'b0;
        #1;
        check_all("R1");
        for (int i = 0; i < 64; i++) pulse("R1");

        summary();
        $finish;
    end
endmodule